// File: doc/BRIEF.md
# Four-Level Masked Interrupt Aggregator

This block gathers level-sensitive interrupt requests from up to four devices on each of four priority levels (numbered 3 to 6) and drives one interrupt line per level. Every level owns a read-only status register, which shows which of its devices are requesting now, and an enable register, which holds the mask of devices allowed to raise that level's line. A level's line is raised while any of its requesting devices is also enabled.

The enable mask is never loaded as a whole. Bit 7 of a write picks the operation: when it is 1, each one in bits 3..0 enables that device; when it is 0, each one in bits 3..0 disables that device. Zeros leave their devices alone. Software can therefore change one device without first reading the mask. Software reaches the registers over a byte-wide bus with an address, a write strobe, write data and read data that is available in the same cycle.

Each level holds a two-state machine. In `LVL_QUIET` the line is low. The transition `raise` moves it to `LVL_RAISED` when status AND enable becomes nonzero. In `LVL_RAISED` the line is high. The transition `drop` returns it to `LVL_QUIET` when that AND becomes zero. Each state holds on its own condition otherwise.

Top module: `irq_level_hub`

## Requirements
- R1: The status register of level L (L = 3..6) is at address 0x100 + 0x10·L. Its bits 3..0 hold device requests `dev_req[4·(L-3)+3 : 4·(L-3)]`, and a change on `dev_req` shows there after the second rising clock edge.
- R2: The enable register of level L is at address 0x104 + 0x10·L. A read returns the current enable mask in bits 3..0.
- R3: A write to an enable register with bit 7 = 1 sets every enable bit whose write-data bit in 3..0 is 1. The result is visible from the next cycle.
- R4: A write to an enable register with bit 7 = 0 clears every enable bit whose write-data bit in 3..0 is 1.
- R5: Enable bits whose write-data bit is 0 keep their value on either kind of write. As examples, 0x81, then 0x86, then 0x02 give masks 0x1, 0x7 and 0x5.
- R6: `irq_out[L-3]` is high exactly when the level's status AND enable was nonzero at the previous rising edge. The line is registered and changes one edge after the status or enable change.
- R7: After reset every enable mask reads 0 and every `irq_out` bit is 0.
- R8: Read data bits 7..4 are always 0. Reading a status register does not clear it.
- R9: Writes to a status register or to an unmapped address change no enable mask and no output. Reads of unmapped addresses return 0.
- R10: A write to one level's enable register leaves the other levels' masks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| dev_req | input | 16 | Level-sensitive device requests, four per level, lowest level in the low nibble |
| irq_out | output | 4 | One registered interrupt line per level, bit 0 for level 3 |

## Verification
Each result has a fixed due time. A request change reaches its status register after two rising edges and reaches its interrupt line after three. An enable write is readable after one edge, and its effect on the line appears one edge later. Read data is combinational and is due within the same cycle as the address. The bench drives all inputs on the falling edge and samples 1 ns later. One directed sequence samples the cycles just before and just after each due edge. The random phase holds its inputs stable for four edges before it compares against the model, so no check lands between the two delays.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;

    typedef enum logic {
        LVL_QUIET,
        LVL_RAISED
    } lvl_state_e;

    function automatic logic [11:0] status_offset(input int unsigned lvl);
        return 12'(32'h100 + 32'h10 * lvl);
    endfunction

    function automatic logic [11:0] enable_offset(input int unsigned lvl);
        return 12'(32'h104 + 32'h10 * lvl);
    endfunction

endpackage

// File: rtl/irq_req_sync.sv
module irq_req_sync #(
    parameter int unsigned WIDTH  = 16,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/irq_level_unit.sv
module irq_level_unit
    import irq_hub_pkg::*;
#(
    parameter int unsigned DEVS   = 4,
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DEVS-1:0]   status_i,
    output logic [DEVS-1:0]   enable_o,
    output logic              irq_o
);
    localparam int unsigned OP_BIT = DATA_W - 1;

    logic [DEVS-1:0] enable_q;
    logic [DEVS-1:0] sel_mask;
    logic            pending;
    lvl_state_e      state_q, state_d;

    assign sel_mask = wdata[DEVS-1:0];
    assign pending  = |(status_i & enable_q);

    // Enable mask: set or clear selected bits only
    always_ff @(posedge clk) begin
        if (!rst_n)
            enable_q <= '0;
        else if (wr_en && wdata[OP_BIT])
            enable_q <= enable_q | sel_mask;
        else if (wr_en)
            enable_q <= enable_q & ~sel_mask;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LVL_QUIET;
        else        state_q <= state_d;
    end

    // Transitions: raise / drop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LVL_QUIET:  if (pending)  state_d = LVL_RAISED;
            LVL_RAISED: if (!pending) state_d = LVL_QUIET;
            default:    state_d = LVL_QUIET;
        endcase
    end

    // Outputs
    always_comb begin
        irq_o    = (state_q == LVL_RAISED);
        enable_o = enable_q;
    end

    assert_set_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[OP_BIT]) |=> ((enable_q & $past(sel_mask)) == $past(sel_mask)));

    assert_clear_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[OP_BIT]) |=> ((enable_q & $past(sel_mask)) == '0));

    assert_unselected_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((enable_q & ~$past(sel_mask)) == ($past(enable_q) & ~$past(sel_mask))));

    assert_line_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(status_i & enable_q))));

endmodule

// File: rtl/irq_level_hub.sv
module irq_level_hub
    import irq_hub_pkg::*;
#(
    parameter int unsigned LEVELS      = 4,
    parameter int unsigned DEVS        = 4,
    parameter int unsigned FIRST_LEVEL = 3,
    parameter int unsigned ADDR_W      = 12,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_wr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [LEVELS*DEVS-1:0] dev_req,
    output logic [LEVELS-1:0]      irq_out
);
    localparam int unsigned REQ_W = LEVELS * DEVS;

    logic [REQ_W-1:0] req_sync;
    logic [DEVS-1:0]  status   [LEVELS];
    logic [DEVS-1:0]  enable   [LEVELS];
    logic [LEVELS-1:0] stat_hit, ena_hit;

    irq_req_sync #(.WIDTH(REQ_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dev_req),
        .sync_o  (req_sync)
    );

    for (genvar g = 0; g < LEVELS; g++) begin : g_level
        assign status[g]   = req_sync[g*DEVS +: DEVS];
        assign stat_hit[g] = (bus_addr == ADDR_W'(status_offset(FIRST_LEVEL + g)));
        assign ena_hit[g]  = (bus_addr == ADDR_W'(enable_offset(FIRST_LEVEL + g)));

        irq_level_unit #(.DEVS(DEVS), .DATA_W(DATA_W)) u_level (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bus_wr && ena_hit[g]),
            .wdata    (bus_wdata),
            .status_i (status[g]),
            .enable_o (enable[g]),
            .irq_o    (irq_out[g])
        );

        assert_other_level_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && !ena_hit[g]) |=> $stable(enable[g]));
    end

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < LEVELS; i++) begin
            if (stat_hit[i]) bus_rdata = DATA_W'(status[i]);
            if (ena_hit[i])  bus_rdata = DATA_W'(enable[i]);
        end
    end

    assert_status_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (|stat_hit)) |=> ($stable(enable[0]) && $stable(enable[LEVELS-1])));

    always_comb begin
        if (rst_n) assert_high_nibble_zero_R8: assert (bus_rdata[DATA_W-1:DEVS] == '0);
    end

endmodule

// File: tb/irq_level_hub_tb_top.sv
`timescale 1ns/1ps
module irq_level_hub_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_addr;
    logic        bus_wr;
    logic [7:0]  bus_wdata;
    logic [7:0]  bus_rdata;
    logic [15:0] dev_req;
    logic [3:0]  irq_out;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [3:0]  exp_en [4];

    always #2 clk = ~clk;

    irq_level_hub dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .dev_req(dev_req), .irq_out(irq_out)
    );

    function automatic logic [11:0] stat_a(input int lv); return 12'(12'h100 + 12'h10 * (lv + 3)); endfunction
    function automatic logic [11:0] ena_a(input int lv);  return 12'(12'h104 + 12'h10 * (lv + 3)); endfunction
    function automatic logic [3:0] exp_irq();
        logic [3:0] r;
        for (int i = 0; i < 4; i++) r[i] = |(dev_req[i*4 +: 4] & exp_en[i]);
        return r;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic peek(input logic [11:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
        for (int i = 0; i < 4; i++)
            if (a == ena_a(i)) exp_en[i] = d[7] ? (exp_en[i] | d[3:0]) : (exp_en[i] & ~d[3:0]);
    endtask

    task automatic check_all(input string tag);
        logic [7:0] v;
        for (int i = 0; i < 4; i++) begin
            peek(stat_a(i), v); chk({tag, " R1 status"}, v, {4'h0, dev_req[i*4 +: 4]});
            peek(stat_a(i), v); chk({tag, " R8 reread"}, v, {4'h0, dev_req[i*4 +: 4]});
            peek(ena_a(i), v);  chk({tag, " R2 enable"}, v, {4'h0, exp_en[i]});
        end
        chk({tag, " R6 irq"}, {4'h0, irq_out}, {4'h0, exp_irq()});
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) exp_en[i] = 4'h0;
        rst_n = 1'b0; bus_addr = '0; bus_wr = 1'b0; bus_wdata = '0; dev_req = 16'hFFFF;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset state
        chk("R7 irq after reset", {4'h0, irq_out}, 8'h00);
        for (int i = 0; i < 4; i++) begin
            peek(ena_a(i), v); chk("R7 enable after reset", v, 8'h00);
        end
        repeat (3) @(negedge clk);
        check_all("reset");

        // R3 R4 R5 example sequence on level 4
        dev_req = 16'h0000;
        wr(ena_a(1), 8'h81); peek(ena_a(1), v); chk("R3 set 0x81", v, 8'h01);
        wr(ena_a(1), 8'h86); peek(ena_a(1), v); chk("R5 set 0x86", v, 8'h07);
        wr(ena_a(1), 8'h02); peek(ena_a(1), v); chk("R4 clear 0x02", v, 8'h05);
        wr(ena_a(1), 8'hFF); peek(ena_a(1), v); chk("R3 set all", v, 8'h0F);
        peek(ena_a(0), v); chk("R10 level3 untouched", v, 8'h00);
        peek(ena_a(2), v); chk("R10 level5 untouched", v, 8'h00);

        // R1 R6 latency on level 5
        wr(ena_a(2), 8'h81);
        @(negedge clk);
        dev_req = 16'h0100;
        peek(stat_a(2), v); chk("R1 status before edge", v, 8'h00);
        @(negedge clk); peek(stat_a(2), v); chk("R1 status after 1 edge", v, 8'h00);
        @(negedge clk); peek(stat_a(2), v); chk("R1 status after 2 edges", v, 8'h01);
        chk("R6 irq not yet", {4'h0, irq_out}, 8'h00);
        @(negedge clk); chk("R6 irq after 3 edges", {4'h0, irq_out}, 8'h04);
        // enable-driven drop: one edge after write
        @(negedge clk);
        bus_addr = ena_a(2); bus_wdata = 8'h01; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0; exp_en[2] = 4'h0;
        chk("R6 irq held one edge", {4'h0, irq_out}, 8'h04);
        @(negedge clk); chk("R6 irq dropped", {4'h0, irq_out}, 8'h00);

        // R9 ignored writes
        wr(ena_a(0), 8'h83);
        wr(stat_a(0), 8'hFF); wr(stat_a(0), 8'h0F);
        wr(12'h108, 8'hFF); wr(12'h800, 8'h0F);
        peek(ena_a(0), v); chk("R9 status write ignored", v, 8'h03);
        peek(12'h108, v); chk("R9 unmapped read zero", v, 8'h00);
        peek(12'h134, v); chk("R9 read 0x134", v, 8'h03);

        // Random phase
        for (int it = 0; it < 400; it++) begin
            int k;
            logic [11:0] a;
            k = $urandom % 10;
            if (k < 4)      a = ena_a(k);
            else if (k < 8) a = stat_a(k - 4);
            else            a = 12'h800 | 12'($urandom % 256);
            wr(a, 8'($urandom));
            @(negedge clk);
            dev_req = 16'($urandom);
            repeat (4) @(negedge clk);
            check_all("rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule